// File: doc/BRIEF.md
# Super-I/O configuration port controller

This block is the configuration front end of a legacy-style Super-I/O device. It occupies two consecutive byte addresses on a simple I/O bus with separate read and write strobes. The lower address is the index port and the next address is the data port. The base address is picked from two candidates by a strap input, and the block ignores every access to any other address.

After reset the block is locked. It opens only when the unlock key byte reaches the index port the required number of times with no other index-port write in between. While open, a write to the index port picks a configuration register, and data-port accesses then reach that register. Registers below a split point form a global area, which holds the logical-device selector and the read-only identity bytes. Registers at or above the split point are forwarded on a register bus to the logical device the selector names. Writing the lock key to the index port closes the block again.

Read data is combinational from the current state, so a read that shares its cycle with a write returns the value from before that write. The logic inside each logical device is not part of this block, and neither is bus arbitration.

Top module: `cfgp_ctrl`

## Requirements
- R1: After reset the block is locked (`cfg_open`=0), `ld_sel`=0x00 and `ld_idx`=0x00. Reads of the index port and of the data port return 0xFF.
- R2: Two index-port writes of 0x87 in a row open the block. `cfg_open` goes to 1 on the clock edge that ends the second write.
- R3: While locked, an index-port write of any value other than 0x87 clears the key count. The sequence 0x87, 0x00, 0x87 leaves the block locked, and one more 0x87 then opens it.
- R4: While open, an index-port write of 0xAA locks the block at that clock edge. After that, data-port reads return 0xFF.
- R5: While locked, data-port writes have no effect: `ld_we` stays 0 and `ld_sel` does not change. Data-port reads return 0xFF and `ld_re` stays 0.
- R6: While open, an index-port write of any value other than 0xAA loads the index register. Index-port reads then return it, and `ld_idx` shows it from the next cycle.
- R7: While open, a data-port write with index 0x07 sets `ld_sel` from the next cycle. A data-port read with index 0x07 returns the selector.
- R8: Identity bytes are read through the data port. Index 0x20 gives the chip ID high byte and 0x21 its low byte. Index 0x22 gives the revision, 0x23 gives 0x19 and 0x24 gives 0x34.
- R9: Data-port writes to identity registers are dropped, and their readback does not change. Any other global index below 0x30 reads 0x00. Accesses below 0x30 never raise `ld_we` or `ld_re`.
- R10: While open with index at or above 0x30, a data-port write raises `ld_we` in that same cycle, with `ld_wdata` equal to the bus byte. A data-port read raises `ld_re` in that cycle and returns `ld_rdata`.
- R11: With `strap_sel`=0 the ports sit at 0x2E/0x2F, and with `strap_sel`=1 at 0x4E/0x4F. Accesses at the other pair have no effect and read 0xFF.
- R12: When a read and a write of the same port fall in one cycle, the read returns the state from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_sel | input | 1 | Base address select: 0 gives the first base, 1 the second |
| io_addr | input | ADDR_W | I/O bus address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational, 0xFF when not decoded |
| cfg_open | output | 1 | Configuration space is unlocked |
| ld_sel | output | 8 | Selected logical device number |
| ld_idx | output | 8 | Current configuration index |
| ld_wdata | output | 8 | Write data forwarded to the logical device |
| ld_we | output | 1 | Device register write strobe |
| ld_re | output | 1 | Device register read strobe |
| ld_rdata | input | 8 | Read data returned by the selected logical device |

## Verification
The readback path and the key or index update can fall in the same cycle. This happens when one bus cycle raises both strobes at the same port address. The bench does this twice. First, during the second unlock key, a read of the index port must still return the locked value 0xFF, and `cfg_open` must be 1 right after that cycle. Second, during the lock key, the index-port read must still return the index held before the write, and the block must be locked right after.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   // Lock state of the configuration space
   typedef enum logic {
      CFG_LOCKED = 1'b0,
      CFG_OPEN   = 1'b1
   } cfg_state_e;

   // Decoded port strobes for one bus cycle
   typedef struct packed {
      logic idx_wr;
      logic idx_rd;
      logic dat_wr;
      logic dat_rd;
   } port_hit_t;

   // Byte of a 16-bit identity word; hi=1 selects the upper byte
   function automatic logic [7:0] id_byte(input logic [15:0] word, input logic hi);
      return hi ? word[15:8] : word[7:0];
   endfunction

endpackage

// File: rtl/cfgp_addr_dec.sv
module cfgp_addr_dec
   import cfgp_pkg::*;
#(
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] BASE_A   = 'h2E,
   parameter logic [ADDR_W-1:0] BASE_B   = 'h4E,
   parameter bit                STRAP_EN = 1'b1
) (
   input  logic              strap_sel,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   output port_hit_t         hit
);

   localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(1);

   logic [ADDR_W-1:0] base;

   generate
      if (STRAP_EN) begin : g_strap
         assign base = strap_sel ? BASE_B : BASE_A;
      end else begin : g_fixed
         logic unused_strap;
         assign unused_strap = strap_sel;
         assign base = BASE_A;
      end
   endgenerate

   logic at_idx;
   logic at_dat;

   assign at_idx = (io_addr == base);
   assign at_dat = (io_addr == (base + DATA_OFS));

   assign hit.idx_wr = at_idx & io_wr;
   assign hit.idx_rd = at_idx & io_rd;
   assign hit.dat_wr = at_dat & io_wr;
   assign hit.dat_rd = at_dat & io_rd;

endmodule

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
   import cfgp_pkg::*;
#(
   parameter int         KEY_REPEAT = 2,
   parameter logic [7:0] UNLOCK_KEY = 8'h87,
   parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       open
);

   cfg_state_e state;
   logic       is_unlock;
   logic       is_lock;

   assign is_unlock = (wdata == UNLOCK_KEY);
   assign is_lock   = (wdata == LOCK_KEY);
   assign open      = (state == CFG_OPEN);

   generate
      if (KEY_REPEAT == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               state <= CFG_LOCKED;
            end else if (idx_wr) begin
               if (state == CFG_LOCKED && is_unlock) state <= CFG_OPEN;
               else if (state == CFG_OPEN && is_lock) state <= CFG_LOCKED;
            end
         end
      end else begin : g_count
         localparam int CW = $clog2(KEY_REPEAT);
         localparam logic [CW-1:0] LAST = CW'(KEY_REPEAT - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               state <= CFG_LOCKED;
               cnt   <= '0;
            end else if (idx_wr) begin
               unique case (state)
                  CFG_LOCKED: begin
                     if (!is_unlock) begin
                        cnt <= '0;
                     end else if (cnt == LAST) begin
                        cnt   <= '0;
                        state <= CFG_OPEN;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  CFG_OPEN: begin
                     cnt <= '0;
                     if (is_lock) state <= CFG_LOCKED;
                  end
                  default: state <= CFG_LOCKED;
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cfgp_glb_regs.sv
module cfgp_glb_regs
   import cfgp_pkg::*;
#(
   parameter logic [7:0] LOCK_KEY  = 8'hAA,
   parameter logic [7:0] LDN_REG   = 8'h07,
   parameter logic [7:0] DEV_SPLIT = 8'h30
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       open,
   input  port_hit_t  hit,
   input  logic [7:0] wdata,
   output logic [7:0] index,
   output logic [7:0] ldn,
   output logic       ld_we,
   output logic       ld_re
);

   logic dev_space;

   assign dev_space = (index >= DEV_SPLIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index <= 8'h00;
         ldn   <= 8'h00;
      end else if (open) begin
         if (hit.idx_wr && (wdata != LOCK_KEY)) index <= wdata;
         if (hit.dat_wr && (index == LDN_REG))  ldn   <= wdata;
      end
   end

   // Device strobes live only for the bus cycle that carries them
   assign ld_we = open & hit.dat_wr & dev_space;
   assign ld_re = open & hit.dat_rd & dev_space;

endmodule

// File: rtl/cfgp_rd_mux.sv
module cfgp_rd_mux
   import cfgp_pkg::*;
#(
   parameter logic [15:0] CHIP_ID   = 16'h5A11,
   parameter logic [7:0]  CHIP_REV  = 8'h03,
   parameter logic [15:0] MFG_ID    = 16'h1934,
   parameter logic [7:0]  LDN_REG   = 8'h07,
   parameter logic [7:0]  ID_BASE   = 8'h20,
   parameter logic [7:0]  DEV_SPLIT = 8'h30
) (
   input  logic       open,
   input  port_hit_t  hit,
   input  logic [7:0] index,
   input  logic [7:0] ldn,
   input  logic [7:0] ld_rdata,
   output logic [7:0] rdata
);

   localparam logic [7:0] IDX_CID_HI = ID_BASE;
   localparam logic [7:0] IDX_CID_LO = ID_BASE + 8'd1;
   localparam logic [7:0] IDX_REV    = ID_BASE + 8'd2;
   localparam logic [7:0] IDX_MFG_HI = ID_BASE + 8'd3;
   localparam logic [7:0] IDX_MFG_LO = ID_BASE + 8'd4;

   logic [7:0] glb_val;

   always_comb begin
      if (index == LDN_REG)         glb_val = ldn;
      else if (index == IDX_CID_HI) glb_val = id_byte(CHIP_ID, 1'b1);
      else if (index == IDX_CID_LO) glb_val = id_byte(CHIP_ID, 1'b0);
      else if (index == IDX_REV)    glb_val = CHIP_REV;
      else if (index == IDX_MFG_HI) glb_val = id_byte(MFG_ID, 1'b1);
      else if (index == IDX_MFG_LO) glb_val = id_byte(MFG_ID, 1'b0);
      else                          glb_val = 8'h00;
   end

   always_comb begin
      rdata = 8'hFF;
      if (open && hit.idx_rd) begin
         rdata = index;
      end else if (open && hit.dat_rd) begin
         rdata = (index >= DEV_SPLIT) ? ld_rdata : glb_val;
      end
   end

endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
   import cfgp_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] BASE_A     = 'h2E,
   parameter logic [ADDR_W-1:0] BASE_B     = 'h4E,
   parameter bit                STRAP_EN   = 1'b1,
   parameter int                KEY_REPEAT = 2,
   parameter logic [7:0]        UNLOCK_KEY = 8'h87,
   parameter logic [7:0]        LOCK_KEY   = 8'hAA,
   parameter logic [7:0]        LDN_REG    = 8'h07,
   parameter logic [7:0]        ID_BASE    = 8'h20,
   parameter logic [7:0]        DEV_SPLIT  = 8'h30,
   parameter logic [15:0]       CHIP_ID    = 16'h5A11,
   parameter logic [7:0]        CHIP_REV   = 8'h03,
   parameter logic [15:0]       MFG_ID     = 16'h1934
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_sel,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic              cfg_open,
   output logic [7:0]        ld_sel,
   output logic [7:0]        ld_idx,
   output logic [7:0]        ld_wdata,
   output logic              ld_we,
   output logic              ld_re,
   input  logic [7:0]        ld_rdata
);

   // Elaboration-time parameter checks
   generate
      if (BASE_A[0] != 1'b0 || BASE_B[0] != 1'b0) begin : g_bad_base
         $error("cfgp_ctrl: base addresses must be even");
      end
      if (KEY_REPEAT < 1) begin : g_bad_rep
         $error("cfgp_ctrl: KEY_REPEAT must be at least 1");
      end
      if (UNLOCK_KEY == LOCK_KEY) begin : g_bad_key
         $error("cfgp_ctrl: lock and unlock keys must differ");
      end
      if (LDN_REG >= DEV_SPLIT || (ID_BASE + 8'd4) >= DEV_SPLIT) begin : g_bad_map
         $error("cfgp_ctrl: global registers must sit below DEV_SPLIT");
      end
   endgenerate

   port_hit_t  hit;
   logic       open;
   logic [7:0] index;
   logic [7:0] ldn;

   cfgp_addr_dec #(
      .ADDR_W   (ADDR_W),
      .BASE_A   (BASE_A),
      .BASE_B   (BASE_B),
      .STRAP_EN (STRAP_EN)
   ) dec_i (
      .strap_sel (strap_sel),
      .io_addr   (io_addr),
      .io_rd     (io_rd),
      .io_wr     (io_wr),
      .hit       (hit)
   );

   cfgp_key_fsm #(
      .KEY_REPEAT (KEY_REPEAT),
      .UNLOCK_KEY (UNLOCK_KEY),
      .LOCK_KEY   (LOCK_KEY)
   ) key_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx_wr (hit.idx_wr),
      .wdata  (io_wdata),
      .open   (open)
   );

   cfgp_glb_regs #(
      .LOCK_KEY  (LOCK_KEY),
      .LDN_REG   (LDN_REG),
      .DEV_SPLIT (DEV_SPLIT)
   ) regs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .open  (open),
      .hit   (hit),
      .wdata (io_wdata),
      .index (index),
      .ldn   (ldn),
      .ld_we (ld_we),
      .ld_re (ld_re)
   );

   cfgp_rd_mux #(
      .CHIP_ID   (CHIP_ID),
      .CHIP_REV  (CHIP_REV),
      .MFG_ID    (MFG_ID),
      .LDN_REG   (LDN_REG),
      .ID_BASE   (ID_BASE),
      .DEV_SPLIT (DEV_SPLIT)
   ) mux_i (
      .open     (open),
      .hit      (hit),
      .index    (index),
      .ldn      (ldn),
      .ld_rdata (ld_rdata),
      .rdata    (io_rdata)
   );

   assign cfg_open = open;
   assign ld_sel   = ldn;
   assign ld_idx   = index;
   assign ld_wdata = io_wdata;

endmodule

// File: rtl/cfgp_ctrl_chk.sv
module cfgp_ctrl_chk #(
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] BASE_A     = 'h2E,
   parameter logic [ADDR_W-1:0] BASE_B     = 'h4E,
   parameter bit                STRAP_EN   = 1'b1,
   parameter logic [7:0]        UNLOCK_KEY = 8'h87,
   parameter logic [7:0]        LOCK_KEY   = 8'hAA
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strap_sel,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_rd,
   input logic              io_wr,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic              cfg_open,
   input logic [7:0]        ld_sel,
   input logic [7:0]        ld_idx,
   input logic              ld_we,
   input logic              ld_re
);

   logic [ADDR_W-1:0] my_base;
   logic              on_idx;
   logic              on_any;

   assign my_base = (STRAP_EN && strap_sel) ? BASE_B : BASE_A;
   assign on_idx  = (io_addr == my_base);
   assign on_any  = on_idx || (io_addr == my_base + ADDR_W'(1));

   AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(io_wr && on_idx && io_wdata == UNLOCK_KEY)); // R2

   AST_LOCK_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && io_wr && on_idx && io_wdata == LOCK_KEY) |=> !cfg_open); // R4

   AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && io_rd && on_any) |-> (io_rdata == 8'hFF)); // R5

   AST_LOCKED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |-> (!ld_we && !ld_re)); // R5

   AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we |-> (io_wr && !io_rd && on_any)); // R10

   AST_SEL_HOLDS_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr |=> $stable(ld_sel)); // R7

   AST_IDX_HOLDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |=> $stable(ld_idx)); // R6

   AST_FOREIGN_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && !on_any) |=> !cfg_open); // R11

endmodule

bind cfgp_ctrl cfgp_ctrl_chk #(
   .ADDR_W     (ADDR_W),
   .BASE_A     (BASE_A),
   .BASE_B     (BASE_B),
   .STRAP_EN   (STRAP_EN),
   .UNLOCK_KEY (UNLOCK_KEY),
   .LOCK_KEY   (LOCK_KEY)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .strap_sel (strap_sel),
   .io_addr   (io_addr),
   .io_rd     (io_rd),
   .io_wr     (io_wr),
   .io_wdata  (io_wdata),
   .io_rdata  (io_rdata),
   .cfg_open  (cfg_open),
   .ld_sel    (ld_sel),
   .ld_idx    (ld_idx),
   .ld_we     (ld_we),
   .ld_re     (ld_re)
);

// File: tb/cfgp_ctrl_tb_top.sv
`timescale 1ns/100ps
module cfgp_ctrl_tb_top;

   localparam logic [15:0] T_CHIP_ID = 16'hC3A7;
   localparam logic [7:0]  T_REV     = 8'h2B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_sel = 1'b0;
   logic [15:0] io_addr = 16'h0000;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = 8'h00;
   logic [7:0]  io_rdata;
   logic        cfg_open;
   logic [7:0]  ld_sel, ld_idx, ld_wdata, ld_rdata;
   logic        ld_we, ld_re;

   always #2.5 clk = ~clk;

   // Simple device model on the register bus
   assign ld_rdata = ld_idx ^ ld_sel ^ 8'h5A;

   cfgp_ctrl #(
      .CHIP_ID  (T_CHIP_ID),
      .CHIP_REV (T_REV)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_sel (strap_sel),
      .io_addr   (io_addr),
      .io_rd     (io_rd),
      .io_wr     (io_wr),
      .io_wdata  (io_wdata),
      .io_rdata  (io_rdata),
      .cfg_open  (cfg_open),
      .ld_sel    (ld_sel),
      .ld_idx    (ld_idx),
      .ld_wdata  (ld_wdata),
      .ld_we     (ld_we),
      .ld_re     (ld_re),
      .ld_rdata  (ld_rdata)
   );

   typedef struct {
      bit         chk_rd;
      logic [7:0] rdata;
      logic       we;
      logic       re;
      logic [7:0] wdata;
      string      tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_chk = 0;
   int   n_bad = 0;

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Driver: one bus cycle, expectation pushed to the scoreboard
   task automatic acc(input bit rd, input bit wr, input logic [15:0] a, input logic [7:0] d,
                      input logic [7:0] exp_rd, input logic ewe, input logic ere, input string tag);
      exp_t e;
      e.chk_rd = rd; e.rdata = exp_rd; e.we = ewe; e.re = ere; e.wdata = d; e.tag = tag;
      sb_q.push_back(e);
      @(posedge clk); #1;
      io_rd = rd; io_wr = wr; io_addr = a; io_wdata = d;
      @(posedge clk); #1;
      io_rd = 1'b0; io_wr = 1'b0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic ewe, input string tag);
      acc(1'b0, 1'b1, a, d, 8'h00, ewe, 1'b0, tag);
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] exp, input logic ere, input string tag);
      acc(1'b1, 1'b0, a, 8'h00, exp, 1'b0, ere, tag);
   endtask

   // Monitor: pops and compares in the middle of each bus cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (io_rd || io_wr) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "scoreboard empty", 16'h0, 16'h1);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               if (e.chk_rd) check(io_rdata == e.rdata, {e.tag, " rdata"}, io_rdata, e.rdata);
               check(ld_we == e.we, {e.tag, " ld_we"}, ld_we, e.we);
               check(ld_re == e.re, {e.tag, " ld_re"}, ld_re, e.re);
               if (e.we) check(ld_wdata == e.wdata, {e.tag, " ld_wdata"}, ld_wdata, e.wdata);
            end
         end else if (ld_we || ld_re) begin
            check(1'b0, "R10 strobe outside bus cycle", {ld_we, ld_re}, 16'h0);
         end
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog expired", 16'h0, 16'h1);
      finish_run();
   end

   localparam logic [15:0] IA = 16'h002E, DA = 16'h002F;
   localparam logic [15:0] IB = 16'h004E, DB = 16'h004F;

   initial begin
      do_reset();
      // R1 reset state
      check(cfg_open == 1'b0, "R1 cfg_open", cfg_open, 0);
      check(ld_sel == 8'h00, "R1 ld_sel", ld_sel, 0);
      check(ld_idx == 8'h00, "R1 ld_idx", ld_idx, 0);
      rd(DA, 8'hFF, 1'b0, "R1 data read");
      rd(IA, 8'hFF, 1'b0, "R1 index read");
      // R5 locked data write ignored
      wr(DA, 8'h55, 1'b0, "R5 locked write");
      rd(DA, 8'hFF, 1'b0, "R5 locked read");
      // R2 + R12: second key with a same-cycle index read
      wr(IA, 8'h87, 1'b0, "R2 key1");
      check(cfg_open == 1'b0, "R2 after one key", cfg_open, 0);
      acc(1'b1, 1'b1, IA, 8'h87, 8'hFF, 1'b0, 1'b0, "R12 read during key2");
      check(cfg_open == 1'b1, "R2 open after key2", cfg_open, 1);
      // R4 relock
      wr(IA, 8'hAA, 1'b0, "R4 lock");
      check(cfg_open == 1'b0, "R4 locked", cfg_open, 0);
      rd(DA, 8'hFF, 1'b0, "R4 read after lock");
      // R3 broken sequence
      wr(IA, 8'h87, 1'b0, "R3 k1");
      wr(IA, 8'h00, 1'b0, "R3 break");
      wr(IA, 8'h87, 1'b0, "R3 k2");
      check(cfg_open == 1'b0, "R3 still locked", cfg_open, 0);
      wr(IA, 8'h87, 1'b0, "R3 k3");
      check(cfg_open == 1'b1, "R3 open", cfg_open, 1);
      // R6 index latch
      wr(IA, 8'h20, 1'b0, "R6 index write");
      check(ld_idx == 8'h20, "R6 ld_idx", ld_idx, 8'h20);
      rd(IA, 8'h20, 1'b0, "R6 index read");
      // R8 identity
      rd(DA, T_CHIP_ID[15:8], 1'b0, "R8 chip id hi");
      wr(IA, 8'h21, 1'b0, "R8 idx");
      rd(DA, T_CHIP_ID[7:0], 1'b0, "R8 chip id lo");
      wr(IA, 8'h22, 1'b0, "R8 idx");
      rd(DA, T_REV, 1'b0, "R8 revision");
      wr(IA, 8'h23, 1'b0, "R8 idx");
      rd(DA, 8'h19, 1'b0, "R8 mfg hi");
      wr(IA, 8'h24, 1'b0, "R8 idx");
      rd(DA, 8'h34, 1'b0, "R8 mfg lo");
      // R9 read-only identity, unused global
      wr(IA, 8'h20, 1'b0, "R9 idx");
      wr(DA, 8'h00, 1'b0, "R9 id write dropped");
      rd(DA, T_CHIP_ID[15:8], 1'b0, "R9 id unchanged");
      wr(IA, 8'h15, 1'b0, "R9 idx");
      rd(DA, 8'h00, 1'b0, "R9 unused global");
      // R7 selector
      wr(IA, 8'h07, 1'b0, "R7 idx");
      wr(DA, 8'h06, 1'b0, "R7 select");
      check(ld_sel == 8'h06, "R7 ld_sel", ld_sel, 8'h06);
      rd(DA, 8'h06, 1'b0, "R7 readback");
      // R10 device space
      wr(IA, 8'h30, 1'b0, "R10 idx");
      check(ld_idx == 8'h30, "R10 ld_idx", ld_idx, 8'h30);
      wr(DA, 8'hC3, 1'b1, "R10 device write");
      rd(DA, 8'h6C, 1'b1, "R10 device read");
      wr(IA, 8'hFE, 1'b0, "R10 idx");
      rd(DA, 8'hA2, 1'b1, "R10 device read top");
      // R12 lock with same-cycle index read, then R5 locked write
      wr(IA, 8'h07, 1'b0, "R5 idx");
      acc(1'b1, 1'b1, IA, 8'hAA, 8'h07, 1'b0, 1'b0, "R12 read during lock");
      check(cfg_open == 1'b0, "R12 locked after", cfg_open, 0);
      wr(DA, 8'h01, 1'b0, "R5 locked selector write");
      check(ld_sel == 8'h06, "R5 ld_sel kept", ld_sel, 8'h06);
      // R11 other strap
      strap_sel = 1'b1;
      do_reset();
      wr(IA, 8'h87, 1'b0, "R11 foreign k1");
      wr(IA, 8'h87, 1'b0, "R11 foreign k2");
      check(cfg_open == 1'b0, "R11 foreign keys", cfg_open, 0);
      wr(IB, 8'h87, 1'b0, "R11 k1");
      wr(IB, 8'h87, 1'b0, "R11 k2");
      check(cfg_open == 1'b1, "R11 open at strap base", cfg_open, 1);
      wr(IA, 8'h07, 1'b0, "R11 foreign index write");
      rd(IA, 8'hFF, 1'b0, "R11 foreign read");
      rd(DA, 8'hFF, 1'b0, "R11 foreign data read");
      rd(IB, 8'h00, 1'b0, "R11 index unchanged");
      rd(DB, 8'h00, 1'b0, "R11 data read index 0");
      repeat (2) @(posedge clk);
      check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
      finish_run();
   end

endmodule